// File: doc/BRIEF.md
# Multiplexed External Code-Fetch Bus Controller

This block sits between a processor core and an external program memory. That memory is reached over one shared 8-bit address/data port and one dedicated 8-bit high-address port. For each fetch request the core presents a 16-bit code address. The controller then runs a fixed bus sequence and hands the returned instruction byte back to the core.

The bus sequence has four steps:
- The controller drives the low address byte on the shared port and pulses the address-latch strobe. An external transparent latch captures the byte while the strobe is high and holds it after the strobe falls.
- The low byte stays driven for one more cycle after the strobe falls.
- The shared port is released for one turnaround cycle.
- The active-low read strobe enables the memory's outputs. The returned byte is captured on the clock edge at which the strobe is released.

The high address byte stays on its own port for the whole cycle.

An active-low external-access input sets where code comes from. When it is low, every address is fetched over the external bus. When it is high, addresses below a parameterised internal boundary belong to on-chip code space. For those, the controller runs no bus activity and only raises a one-cycle internal-select pulse. Addresses at or above the boundary still go over the external bus.

Top module: `xcode_bus`

## Requirements
- R1: While reset is asserted: `psen_n` is 1, `ale` is 0, `ad_oe` is 0, `fetch_rdy` is 1, `rsp_valid` is 0 and `int_sel` is 0.
- R2: A request is accepted on a rising clock edge where `fetch_req` and `fetch_rdy` are both 1. For an external fetch, `fetch_rdy` is 0 from the following cycle up to, but not including, the cycle in which `rsp_valid` is 1.
- R3: After an external accept, `ale` is 1 for exactly ALE_CYC cycles. During those cycles `ad_oe` is 1, `ad_out` equals address bits [7:0] and `hi_addr` equals address bits [15:8].
- R4: In the cycle right after `ale` falls, `ad_oe` is still 1 and `ad_out` still carries the same low address byte.
- R5: `ad_oe` is 0 for one full cycle before `psen_n` goes low. `ad_oe` = 1 and `psen_n` = 0 never occur in the same cycle.
- R6: `psen_n` is 0 for exactly RD_CYC consecutive cycles per external fetch.
- R7: The byte on `ad_in` at the rising edge where `psen_n` returns to 1 appears on `rsp_data`. In that same cycle, which is ALE_CYC+RD_CYC+3 cycles after the accept cycle, `rsp_valid` is 1 for exactly one cycle.
- R8: With `ext_access_n` = 0 at accept, every address (0x0000 to 0xFFFF) is fetched externally.
- R9: With `ext_access_n` = 1 at accept and an address below INT_SIZE (default 0x1000), `int_sel` is 1 for the one cycle after the accept. In that fetch `ale` stays 0, `psen_n` stays 1 and `rsp_valid` stays 0, and `fetch_rdy` is 1 again in the next cycle. An address at or above INT_SIZE is fetched externally.
- R10: A request held high while `rsp_valid` is 1 is accepted in that cycle, so `ale` rises in the very next cycle with the new low address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Core requests a code fetch |
| fetch_addr | input | 16 | Code address of the request |
| fetch_rdy | output | 1 | Controller can accept a request |
| ext_access_n | input | 1 | Active low: fetch all code externally |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds the fetched byte |
| rsp_data | output | 8 | Fetched instruction byte |
| int_sel | output | 1 | One-cycle pulse: request falls in internal code space |
| ale | output | 1 | Address-latch strobe for the external latch |
| ad_out | output | 8 | Value driven onto the shared port |
| ad_oe | output | 1 | Shared-port drive enable |
| ad_in | input | 8 | Value read from the shared port |
| hi_addr | output | 8 | High address byte port |
| psen_n | output | 1 | Active-low program-memory output enable |

## Verification
Two events can land in the same cycle: the response pulse of one fetch and the acceptance of the next request. The bench provokes this by holding `fetch_req` high with a second address while the first fetch is still in flight. It then checks three things: the first byte arrives intact, `fetch_rdy` is high in the pulse cycle, and `ale` rises in the very next cycle carrying the second address's low byte. The bench also models the shared port and the external latch, and flags any cycle in which the controller and the memory would both drive the port.

// File: rtl/xcb_pkg.sv
package xcb_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ADDR = 3'd1,
    S_HOLD = 3'd2,
    S_TURN = 3'd3,
    S_READ = 3'd4,
    S_INT  = 3'd5
  } xcb_state_t;
endpackage

// File: rtl/xcb_seq.sv
module xcb_seq
  import xcb_pkg::*;
#(
  parameter int ALE_CYC = 1,
  parameter int RD_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       go_int,
  output xcb_state_t state,
  output logic       accept,
  output logic       done
);
  localparam int MAXC = (ALE_CYC > RD_CYC) ? ALE_CYC : RD_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ALE_LD = CW'(ALE_CYC - 1);
  localparam logic [CW-1:0] RD_LD  = CW'(RD_CYC - 1);

  xcb_state_t      st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    accept = 1'b0;
    done   = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (req) begin
          accept = 1'b1;
          if (go_int) begin
            st_d = S_INT;
          end else begin
            st_d   = S_ADDR;
            cnt_d  = ALE_LD;
            cnt_en = 1'b1;
          end
        end
      end
      S_ADDR: begin
        if (cnt_q == '0) begin
          st_d = S_HOLD;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      S_HOLD: st_d = S_TURN;
      S_TURN: begin
        st_d   = S_READ;
        cnt_d  = RD_LD;
        cnt_en = 1'b1;
      end
      S_READ: begin
        if (cnt_q == '0) begin
          st_d = S_IDLE;
          done = 1'b1;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      S_INT:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/xcb_dpath.sv
module xcb_dpath
  import xcb_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  xcb_state_t           state,
  input  logic                 accept,
  input  logic                 done,
  input  logic [LO_W+HI_W-1:0] addr_in,
  input  logic [LO_W-1:0]      ad_in,
  output logic                 rsp_valid,
  output logic [LO_W-1:0]      rsp_data,
  output logic                 int_sel,
  output logic                 ale,
  output logic [LO_W-1:0]      ad_out,
  output logic                 ad_oe,
  output logic [HI_W-1:0]      hi_addr,
  output logic                 psen_n
);
  localparam int AW = LO_W + HI_W;

  logic [AW-1:0]   addr_q;
  logic [LO_W-1:0] data_q;
  logic            vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (accept) addr_q <= addr_in;
      if (done)   data_q <= ad_in;
      vld_q <= done;
    end
  end

  always_comb begin
    ale     = (state == S_ADDR);
    ad_oe   = (state == S_ADDR) || (state == S_HOLD);
    ad_out  = ad_oe ? addr_q[LO_W-1:0] : '0;
    psen_n  = (state != S_READ);
    int_sel = (state == S_INT);
    hi_addr = addr_q[AW-1:LO_W];
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = data_q;
endmodule

// File: rtl/xcode_bus.sv
module xcode_bus
  import xcb_pkg::*;
#(
  parameter int LO_W     = 8,
  parameter int HI_W     = 8,
  parameter int INT_SIZE = 4096,
  parameter int ALE_CYC  = 1,
  parameter int RD_CYC   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_req,
  input  logic [LO_W+HI_W-1:0] fetch_addr,
  output logic                 fetch_rdy,
  input  logic                 ext_access_n,
  output logic                 rsp_valid,
  output logic [LO_W-1:0]      rsp_data,
  output logic                 int_sel,
  output logic                 ale,
  output logic [LO_W-1:0]      ad_out,
  output logic                 ad_oe,
  input  logic [LO_W-1:0]      ad_in,
  output logic [HI_W-1:0]      hi_addr,
  output logic                 psen_n
);
  localparam int AW = LO_W + HI_W;
  localparam logic [AW:0] INT_LIM = (AW+1)'(INT_SIZE);

  xcb_state_t state;
  logic       accept, done, go_int;

  assign go_int    = ext_access_n && ({1'b0, fetch_addr} < INT_LIM);
  assign fetch_rdy = (state == S_IDLE);

  xcb_seq #(.ALE_CYC(ALE_CYC), .RD_CYC(RD_CYC)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (fetch_req),
    .go_int (go_int),
    .state  (state),
    .accept (accept),
    .done   (done)
  );

  xcb_dpath #(.LO_W(LO_W), .HI_W(HI_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .accept    (accept),
    .done      (done),
    .addr_in   (fetch_addr),
    .ad_in     (ad_in),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .int_sel   (int_sel),
    .ale       (ale),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .hi_addr   (hi_addr),
    .psen_n    (psen_n)
  );
endmodule

// File: rtl/xcode_bus_chk.sv
module xcode_bus_chk #(
  parameter int LO_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_rdy,
  input logic            ale,
  input logic            ad_oe,
  input logic [LO_W-1:0] ad_out,
  input logic            psen_n,
  input logic            rsp_valid,
  input logic            int_sel
);
  // R2
  bus_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ale || ad_oe || !psen_n) |-> !fetch_rdy);

  // R3
  ale_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ad_oe);

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (ad_oe && $stable(ad_out)));

  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ad_oe && !psen_n));

  // R5
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |-> !$past(ad_oe));

  // R7
  sample_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(psen_n));

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  int_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_sel |-> (psen_n && !ale && !ad_oe && !rsp_valid));
endmodule

bind xcode_bus xcode_bus_chk #(.LO_W(LO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fetch_rdy (fetch_rdy),
  .ale       (ale),
  .ad_oe     (ad_oe),
  .ad_out    (ad_out),
  .psen_n    (psen_n),
  .rsp_valid (rsp_valid),
  .int_sel   (int_sel)
);

// File: tb/xcode_bus_tb.sv
module xcode_bus_tb;
  localparam int A = 1;
  localparam int R = 2;
  localparam int L = A + R + 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_req;
  logic [15:0] fetch_addr;
  logic        fetch_rdy;
  logic        ext_access_n;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        int_sel;
  logic        ale;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in;
  logic [7:0]  hi_addr;
  logic        psen_n;

  logic [7:0]  lat;
  logic [7:0]  pins;
  int          n_run = 0;
  int          n_fail = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  xcode_bus #(.INT_SIZE(4096), .ALE_CYC(A), .RD_CYC(R)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_rdy(fetch_rdy), .ext_access_n(ext_access_n), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .int_sel(int_sel), .ale(ale), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .hi_addr(hi_addr), .psen_n(psen_n)
  );

  function automatic logic [7:0] mem(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5C;
  endfunction

  always_comb begin
    if (ad_oe)        pins = ad_out;
    else if (!psen_n) pins = mem({hi_addr, lat});
    else              pins = 8'hFF;
  end
  assign ad_in = pins;

  always_latch begin
    if (ale) lat = pins;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [15:0] a, input logic en, input bit internal);
    int ale_cnt = 0, ps_cnt = 0, vk = 0, intk = 0;
    bit clash = 0, rdy_bad = 0, adr_bad = 0, hold_bad = 0;
    logic [7:0] got = 8'h00;
    @(negedge clk);
    fetch_addr = a; ext_access_n = en; fetch_req = 1'b1;
    chk(fetch_rdy, "R2 ready before accept", fetch_rdy, 1);
    @(negedge clk);
    fetch_req = 1'b0;
    for (int k = 1; k <= L + 2; k++) begin
      if (ale) ale_cnt++;
      if (!psen_n) ps_cnt++;
      if (ad_oe && !psen_n) clash = 1;
      if (rsp_valid) begin vk = k; got = rsp_data; end
      if (int_sel) intk = k;
      if (!internal && k < L && fetch_rdy) rdy_bad = 1;
      if (!internal && k <= A &&
          (!ad_oe || ad_out != a[7:0] || hi_addr != a[15:8])) adr_bad = 1;
      if (!internal && k == A + 1 && (ale || !ad_oe || ad_out != a[7:0])) hold_bad = 1;
      if (!internal && k == A + 2 && (ad_oe || !psen_n)) hold_bad = 1;
      if (k < L + 2) @(negedge clk);
    end
    if (internal) begin
      chk(intk == 1, "R9 int_sel pulse cycle", intk, 1);
      chk(ale_cnt == 0 && ps_cnt == 0 && vk == 0, "R9 no bus activity",
          ale_cnt + ps_cnt + vk, 0);
      chk(fetch_rdy, "R9 ready after internal", fetch_rdy, 1);
    end else begin
      chk(!rdy_bad, "R2 ready low while busy", rdy_bad, 0);
      chk(ale_cnt == A && !adr_bad, "R3 address phase", ale_cnt, A);
      chk(!hold_bad && lat == a[7:0], "R4 latched low address", lat, a[7:0]);
      chk(!clash, "R5 port contention", clash, 0);
      chk(ps_cnt == R, "R6 read strobe length", ps_cnt, R);
      chk(vk == L, "R7 response cycle", vk, L);
      chk(got == mem(a), en ? "R9 external data above boundary" : "R8 external data",
          got, mem(a));
      chk(intk == 0, "R8 no int_sel", intk, 0);
    end
  endtask

  task automatic back_to_back(input logic [15:0] a1, input logic [15:0] a2);
    int k = 1;
    @(negedge clk);
    fetch_addr = a1; ext_access_n = 1'b0; fetch_req = 1'b1;
    @(negedge clk);
    fetch_addr = a2;
    while (!rsp_valid && k < 20) begin @(negedge clk); k++; end
    chk(k == L && rsp_data == mem(a1), "R10 first byte", rsp_data, mem(a1));
    chk(fetch_rdy, "R10 ready in pulse cycle", fetch_rdy, 1);
    @(negedge clk);
    fetch_req = 1'b0;
    chk(ale && ad_out == a2[7:0], "R10 next address phase", ad_out, a2[7:0]);
    repeat (L - 1) @(negedge clk);
    chk(rsp_valid && rsp_data == mem(a2), "R10 second byte", rsp_data, mem(a2));
  endtask

  initial begin
    rst_n = 1'b0; fetch_req = 1'b0; fetch_addr = 16'h0; ext_access_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(psen_n && !ale && !ad_oe && fetch_rdy && !rsp_valid && !int_sel,
        "R1 reset state", {psen_n, ale, ad_oe, fetch_rdy, rsp_valid, int_sel}, 6'b100100);
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) do_fetch(16'(i * 257), 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) do_fetch(16'(16'h1234 + i * 16'h0F1B), 1'b0, 1'b0);
    do_fetch(16'hFFFF, 1'b0, 1'b0);
    do_fetch(16'h0000, 1'b0, 1'b0);
    for (int a = 16'h0FF0; a < 16'h1010; a++)
      do_fetch(16'(a), 1'b1, (a < 4096));
    do_fetch(16'h0000, 1'b1, 1'b1);
    do_fetch(16'hFFFF, 1'b1, 1'b0);
    back_to_back(16'hA55A, 16'h3CC3);
    back_to_back(16'h00FF, 16'hFF00);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule